// File: doc/BRIEF.md
# I2C Four-Phase Bit Timing Generator

This block produces the clock and data line levels for one I2C bit cell or bus condition at a time. A shared prescaler divides the system clock into ticks. Each bit cell is then split into four phases, and the length of each phase is set in ticks by its own field. This lets the low time, the rise margin, the high time and the hold time be tuned separately. The same phase timing produces single data bits, start conditions, repeated starts and stop conditions.

A byte or transaction sequencer sits above this block. It issues one command per bit cell and gets back one-cycle strobes at the points where the data line is driven, where the clock rises, where the data line is sampled and where the clock falls. A done pulse marks the end of the cell. Line outputs are levels, with 1 meaning released (pulled high) and 0 meaning pulled low. The pads are outside the block, and the real clock line comes back in so that a target can stretch the clock.

Timing fields can be loaded only while the block is disabled. Disabling the block also acts as a soft reset of its state machine.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset both line outputs read 1 (released), no strobe or done is asserted, and `cmd_ready` is 0 while `enable` is 0 and 1 once `enable` is 1 with no cell in progress.
- R2: With effective divide D and effective phase lengths P0..P3, a cell accepted at a clock edge spends D*Pk cycles in phase k. `done` is high in exactly the D*(P0+P1+P2+P3)-th cycle after the accepting edge.
- R3: A divide value of 0 behaves exactly as 1, and a phase length of 0 behaves exactly as 1.
- R4: For a data bit (`cmd_kind` 0), `scl_o` is 0 in phases 0 and 3 and 1 in phases 1 and 2, and `sda_o` equals `cmd_bit` in all four phases.
- R5: `stb_drive` is high in the accepting cycle. `stb_rise` is high in the last cycle of phase 0. `stb_sample` and `stb_fall` are high in the last cycle of phase 2. At most one of `stb_drive`, `stb_rise`, `stb_sample` and `done` is high in any cycle.
- R6: `rx_bit` takes the value of `sda_in` at the `stb_sample` cycle and holds it until the next sample.
- R7: A start (`cmd_kind` 1) gives `scl_o` = 1,1,1,0 and `sda_o` = 1,1,0,0 over phases 0..3. A repeated start (`cmd_kind` 2) gives `scl_o` = 0,1,1,0 and the same `sda_o`.
- R8: A stop (`cmd_kind` 3) gives `scl_o` = 0,1,1,1 and `sda_o` = 0,0,1,1 over phases 0..3.
- R9: Between cells the line outputs hold the levels of the last phase of the previous cell and do not change.
- R10: While the block releases SCL and `scl_in` reads 0, the prescaler and the phase counter stop. Each such cycle lengthens the cell by one cycle.
- R11: The divide and phase-length inputs are captured only while `enable` is 0. Changes made while enabled have no effect on timing.
- R12: Clearing `enable` aborts any cell: in the next cycle both lines read 1, `done` is 0 and no cell is in progress.
- R13: A command presented while a cell is in progress is ignored and does not change that cell's waveform or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | 1 = run; 0 = disabled (soft reset, timing fields load) |
| cfg_div | input | DIV_W | Prescaler divide, 0 treated as 1 |
| cfg_p0 | input | STEP_W | Phase 0 length in ticks |
| cfg_p1 | input | STEP_W | Phase 1 length in ticks |
| cfg_p2 | input | STEP_W | Phase 2 length in ticks |
| cfg_p3 | input | STEP_W | Phase 3 length in ticks |
| cmd_valid | input | 1 | Command request |
| cmd_kind | input | 2 | 0 bit, 1 start, 2 repeated start, 3 stop |
| cmd_bit | input | 1 | Data value for a bit cell |
| cmd_ready | output | 1 | Enabled and idle |
| scl_in | input | 1 | Sensed clock line |
| sda_in | input | 1 | Sensed data line |
| scl_o | output | 1 | Clock line level, 1 = released |
| sda_o | output | 1 | Data line level, 1 = released |
| stb_drive | output | 1 | Data drive point |
| stb_rise | output | 1 | Clock rise point |
| stb_sample | output | 1 | Data sample point |
| stb_fall | output | 1 | Clock fall point |
| done | output | 1 | Last cycle of the cell |
| rx_bit | output | 1 | Last sampled data value |

## Verification
The bench builds the block with its default 8-bit divide and phase fields. It sweeps divide values 0 to 3 against several small phase-length sets that include zeros, so the zero substitution and every phase boundary of all four command kinds occur within a few dozen cycles per cell. The three realistic bus-speed settings are also run, with cells up to 240 cycles. Stretching, loading while enabled, commands presented while busy, and an abort in mid-cell are each placed at cycles the bench computes from the phase arithmetic.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    localparam int unsigned NUM_PHASES = 4;
    localparam int unsigned PH_W       = $clog2(NUM_PHASES);

    typedef enum logic [1:0] {
        COND_BIT    = 2'd0,
        COND_START  = 2'd1,
        COND_RSTART = 2'd2,
        COND_STOP   = 2'd3
    } cond_e;

    // 1 = released (high), 0 = pulled low
    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    typedef struct packed {
        cond_e kind;
        logic  bit_val;
    } cmd_t;

    // Line levels for every command kind in every phase
    function automatic lines_t phase_lines(cond_e kind, logic [PH_W-1:0] ph, logic bit_val);
        lines_t l;
        l.scl = 1'b1;
        l.sda = 1'b1;
        case (kind)
            COND_BIT: begin
                l.scl = (ph == 2'd1) || (ph == 2'd2);
                l.sda = bit_val;
            end
            COND_START: begin
                l.scl = (ph != 2'd3);
                l.sda = (ph < 2'd2);
            end
            COND_RSTART: begin
                l.scl = (ph == 2'd1) || (ph == 2'd2);
                l.sda = (ph < 2'd2);
            end
            COND_STOP: begin
                l.scl = (ph != 2'd0);
                l.sda = (ph >= 2'd2);
            end
            default: ;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/i2c_bt_cfg_shadow.sv
module i2c_bt_cfg_shadow
    import i2c_bt_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned STEP_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                load,
    input  logic [DIV_W-1:0]                    div_in,
    input  logic [NUM_PHASES-1:0][STEP_W-1:0]   step_in,
    output logic [DIV_W-1:0]                    div_eff,
    output logic [NUM_PHASES-1:0][STEP_W-1:0]   step_eff
);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (load) div_q <= div_in;
    end

    // zero would stall the prescaler: substitute one
    assign div_eff = (div_q == '0) ? DIV_W'(1) : div_q;

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        logic [STEP_W-1:0] step_q;

        always_ff @(posedge clk) begin
            if (rst)       step_q <= '0;
            else if (load) step_q <= step_in[g];
        end

        assign step_eff[g] = (step_q == '0) ? STEP_W'(1) : step_q;
    end

endmodule

// File: rtl/i2c_bt_prescaler.sv
module i2c_bt_prescaler #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             freeze,
    input  logic [DIV_W-1:0] div_eff,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == div_eff - DIV_W'(1));
    assign tick = run && !freeze && wrap;

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt_q <= '0;
        else if (!freeze) cnt_q <= wrap ? '0 : cnt_q + DIV_W'(1);
    end

endmodule

// File: rtl/i2c_bt_phase_seq.sv
module i2c_bt_phase_seq
    import i2c_bt_pkg::*;
#(
    parameter int unsigned STEP_W = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               enable,
    input  logic                               start,
    input  logic                               tick,
    input  logic [NUM_PHASES-1:0][STEP_W-1:0]  step_eff,
    output logic                               busy,
    output logic [PH_W-1:0]                    phase,
    output logic                               adv,
    output logic                               last
);

    localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PHASES - 1);

    logic              busy_q;
    logic [PH_W-1:0]   phase_q;
    logic [STEP_W-1:0] step_q;
    logic              step_end;

    assign step_end = (step_q == step_eff[phase_q] - STEP_W'(1));
    assign adv      = busy_q && tick && step_end;
    assign last     = adv && (phase_q == LAST_PH);
    assign busy     = busy_q;
    assign phase    = phase_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
            step_q  <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            phase_q <= '0;
            step_q  <= '0;
        end else if (busy_q && tick) begin
            if (step_end) begin
                step_q <= '0;
                if (phase_q == LAST_PH) busy_q  <= 1'b0;
                else                    phase_q <= phase_q + PH_W'(1);
            end else begin
                step_q <= step_q + STEP_W'(1);
            end
        end
    end

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
    import i2c_bt_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [STEP_W-1:0] cfg_p0,
    input  logic [STEP_W-1:0] cfg_p1,
    input  logic [STEP_W-1:0] cfg_p2,
    input  logic [STEP_W-1:0] cfg_p3,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic              cmd_bit,
    output logic              cmd_ready,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_o,
    output logic              sda_o,
    output logic              stb_drive,
    output logic              stb_rise,
    output logic              stb_sample,
    output logic              stb_fall,
    output logic              done,
    output logic              rx_bit
);

    localparam logic [PH_W-1:0] PH_RISE   = PH_W'(0);
    localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(2);

    logic [DIV_W-1:0]                  div_eff;
    logic [NUM_PHASES-1:0][STEP_W-1:0] step_eff;
    logic                              tick;
    logic                              busy;
    logic [PH_W-1:0]                   phase;
    logic                              adv;
    logic                              last;
    logic                              accept;
    logic                              freeze;
    cmd_t                              cmd_q;
    cond_e                             kind_q;
    lines_t                            lv_now;
    lines_t                            held_q;
    logic                              rx_q;

    i2c_bt_cfg_shadow #(.DIV_W(DIV_W), .STEP_W(STEP_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (!enable),
        .div_in   (cfg_div),
        .step_in  ({cfg_p3, cfg_p2, cfg_p1, cfg_p0}),
        .div_eff  (div_eff),
        .step_eff (step_eff)
    );

    i2c_bt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .freeze  (freeze),
        .div_eff (div_eff),
        .tick    (tick)
    );

    i2c_bt_phase_seq #(.STEP_W(STEP_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .start    (accept),
        .tick     (tick),
        .step_eff (step_eff),
        .busy     (busy),
        .phase    (phase),
        .adv      (adv),
        .last     (last)
    );

    assign cmd_ready = enable && !busy;
    assign accept    = cmd_ready && cmd_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '{kind: COND_BIT, bit_val: 1'b1};
        end else if (accept) begin
            cmd_q <= '{kind: cond_e'(cmd_kind), bit_val: cmd_bit};
        end
    end

    assign kind_q = cmd_q.kind;
    assign lv_now = phase_lines(cmd_q.kind, phase, cmd_q.bit_val);

    // target holding SCL low while it is released
    assign freeze = busy && lv_now.scl && !scl_in;

    always_ff @(posedge clk) begin
        if (rst || !enable) held_q <= '{scl: 1'b1, sda: 1'b1};
        else if (last)      held_q <= lv_now;
    end

    assign scl_o = busy ? lv_now.scl : held_q.scl;
    assign sda_o = busy ? lv_now.sda : held_q.sda;

    assign stb_drive  = accept;
    assign stb_rise   = adv && (phase == PH_RISE);
    assign stb_sample = adv && (phase == PH_SAMPLE);
    assign stb_fall   = stb_sample;
    assign done       = last;

    always_ff @(posedge clk) begin
        if (rst)             rx_q <= 1'b0;
        else if (stb_sample) rx_q <= sda_in;
    end

    assign rx_bit = rx_q;

endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk
    import i2c_bt_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            enable,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic            busy,
    input logic [PH_W-1:0] phase,
    input logic            hold,
    input cond_e           kind_q,
    input logic            scl_o,
    input logic            sda_o,
    input logic            stb_drive,
    input logic            stb_rise,
    input logic            stb_sample,
    input logic            stb_fall,
    input logic            done
);

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb_drive, stb_rise, stb_sample, done}));

    a_r5_rise_releases_scl: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && enable) |=> scl_o);

    a_r4_fall_pulls_scl: assert property (@(posedge clk) disable iff (rst)
        (stb_fall && enable && kind_q == COND_BIT) |=> !scl_o);

    a_r12_disable_releases: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (scl_o && sda_o && !done && !busy));

    a_r9_idle_lines_stable: assert property (@(posedge clk) disable iff (rst)
        (enable && cmd_ready && !cmd_valid) |=> ($stable(scl_o) && $stable(sda_o)));

    a_r10_stretch_holds_phase: assert property (@(posedge clk) disable iff (rst)
        (enable && hold) |=> ($stable(phase) && busy));

    a_r2_done_ends_cell: assert property (@(posedge clk) disable iff (rst)
        (enable && done) |=> !busy);

endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .busy       (busy),
    .phase      (phase),
    .hold       (freeze),
    .kind_q     (kind_q),
    .scl_o      (scl_o),
    .sda_o      (sda_o),
    .stb_drive  (stb_drive),
    .stb_rise   (stb_rise),
    .stb_sample (stb_sample),
    .stb_fall   (stb_fall),
    .done       (done)
);

// File: tb/i2c_bit_timer_tb.sv
module i2c_bit_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [7:0] cfg_div = '0, cfg_p0 = '0, cfg_p1 = '0, cfg_p2 = '0, cfg_p3 = '0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_kind = '0;
    logic       cmd_bit = 1'b0;
    logic       cmd_ready, scl_o, sda_o, scl_in, sda_in;
    logic       stb_drive, stb_rise, stb_sample, stb_fall, done, rx_bit;
    logic       stretch = 1'b0;
    logic       slave_sda = 1'b1;

    int checks = 0;
    int errors = 0;
    int wd = 0;
    int e_div;
    int e_p[4];

    always #4 clk = ~clk;

    assign scl_in = scl_o & ~stretch;
    assign sda_in = sda_o & slave_sda;

    i2c_bit_timer u_dut (
        .clk(clk), .rst(rst), .enable(enable),
        .cfg_div(cfg_div), .cfg_p0(cfg_p0), .cfg_p1(cfg_p1), .cfg_p2(cfg_p2), .cfg_p3(cfg_p3),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bit(cmd_bit), .cmd_ready(cmd_ready),
        .scl_in(scl_in), .sda_in(sda_in), .scl_o(scl_o), .sda_o(sda_o),
        .stb_drive(stb_drive), .stb_rise(stb_rise), .stb_sample(stb_sample), .stb_fall(stb_fall),
        .done(done), .rx_bit(rx_bit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int exp_phase(input int ce);
        int t = (ce - 1) / e_div;
        int acc = 0;
        for (int k = 0; k < 4; k++) begin
            acc += e_p[k];
            if (t < acc) return k;
        end
        return 3;
    endfunction

    // {scl, sda} from the requirement tables
    function automatic logic [1:0] exp_lv(input int k, input int ph, input logic b);
        case (k)
            0: return {(ph == 1 || ph == 2) ? 1'b1 : 1'b0, b};
            1: return {(ph != 3) ? 1'b1 : 1'b0, (ph < 2) ? 1'b1 : 1'b0};
            2: return {(ph == 1 || ph == 2) ? 1'b1 : 1'b0, (ph < 2) ? 1'b1 : 1'b0};
            default: return {(ph != 0) ? 1'b1 : 1'b0, (ph >= 2) ? 1'b1 : 1'b0};
        endcase
    endfunction

    task automatic configure(input int d, input int a, input int b, input int c, input int e);
        @(negedge clk);
        enable  = 1'b0;
        cfg_div = 8'(d); cfg_p0 = 8'(a); cfg_p1 = 8'(b); cfg_p2 = 8'(c); cfg_p3 = 8'(e);
        @(negedge clk);
        enable = 1'b1;
        e_div = eff(d); e_p[0] = eff(a); e_p[1] = eff(b); e_p[2] = eff(c); e_p[3] = eff(e);
    endtask

    task automatic run_cmd(input int k, input logic b, input logic slave, input int n,
                           input bit hold_valid, input string ttag);
        int c, ce, p0c, rise, samp, fall, donec, bad, bad_c, bad_a, bad_e, drv_bad;
        logic [1:0] el;
        string wtag;
        wtag = (k == 0) ? "R4" : ((k == 3) ? "R8" : "R7");
        if (hold_valid) wtag = {wtag, " R13"};
        @(negedge clk);
        cmd_kind = 2'(k); cmd_bit = b; slave_sda = slave; cmd_valid = 1'b1;
        #1;
        chk(stb_drive === 1'b1, "R5 drive strobe at accept", int'(stb_drive), 1);
        @(negedge clk);
        if (hold_valid) begin cmd_kind = 2'd3; cmd_bit = ~b; end
        else cmd_valid = 1'b0;
        p0c = e_div * e_p[0];
        c = 1; rise = -1; samp = -1; fall = -1; donec = -1; bad = 0; drv_bad = 0;
        bad_c = 0; bad_a = 0; bad_e = 0;
        while (donec < 0 && c < 4000) begin
            stretch = (n > 0 && c > p0c && c <= p0c + n);
            #1;
            ce = (c <= p0c) ? c : ((c <= p0c + n) ? p0c + 1 : c - n);
            el = exp_lv(k, exp_phase(ce), b);
            if ({scl_o, sda_o} !== el && bad == 0) begin
                bad = 1; bad_c = c; bad_a = int'({scl_o, sda_o}); bad_e = int'(el);
            end
            if (stb_drive) drv_bad = 1;
            if (stb_rise && rise < 0) rise = c;
            if (stb_sample && samp < 0) samp = c;
            if (stb_fall && fall < 0) fall = c;
            if (done) begin donec = c; cmd_valid = 1'b0; end
            c++;
            if (donec < 0) @(negedge clk);
        end
        stretch = 1'b0;
        if (bad != 0) $display("  waveform mismatch at cycle %0d", bad_c);
        chk(bad == 0, {wtag, " line levels per phase"}, bad_a, bad_e);
        chk(drv_bad == 0, "R5 drive strobe only at accept", drv_bad, 0);
        chk(rise == p0c, {"R5 rise strobe cycle ", ttag}, rise, p0c);
        chk(samp == e_div * (e_p[0] + e_p[1] + e_p[2]) + n, {"R5 sample strobe cycle ", ttag},
            samp, e_div * (e_p[0] + e_p[1] + e_p[2]) + n);
        chk(fall == samp, "R5 fall strobe with sample", fall, samp);
        chk(donec == e_div * (e_p[0] + e_p[1] + e_p[2] + e_p[3]) + n, {"done cycle ", ttag},
            donec, e_div * (e_p[0] + e_p[1] + e_p[2] + e_p[3]) + n);
        @(negedge clk);
        #1;
        chk({scl_o, sda_o} === exp_lv(k, 3, b), "R9 held levels after cell",
            int'({scl_o, sda_o}), int'(exp_lv(k, 3, b)));
        chk(cmd_ready === 1'b1, "R9 ready after cell", int'(cmd_ready), 1);
        if (k == 0) chk(rx_bit === (b & slave), "R6 sampled bit", int'(rx_bit), int'(b & slave));
        @(negedge clk);
        #1;
        chk({scl_o, sda_o} === exp_lv(k, 3, b), "R9 levels stable while idle",
            int'({scl_o, sda_o}), int'(exp_lv(k, 3, b)));
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", wd);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int divs[4];
        int sets[4][4];
        divs = '{0, 1, 2, 3};
        sets = '{'{1, 1, 1, 1}, '{0, 2, 1, 3}, '{3, 1, 2, 0}, '{2, 3, 1, 1}};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(scl_o === 1'b1 && sda_o === 1'b1, "R1 lines released after reset",
            int'({scl_o, sda_o}), 3);
        chk(cmd_ready === 1'b0, "R1 not ready while disabled", int'(cmd_ready), 0);
        chk({stb_drive, stb_rise, stb_sample, stb_fall, done} === 5'b0, "R1 no strobes",
            int'({stb_drive, stb_rise, stb_sample, stb_fall, done}), 0);
        @(negedge clk);
        enable = 1'b1;
        #1;
        chk(cmd_ready === 1'b1, "R1 ready once enabled", int'(cmd_ready), 1);

        // sweep over divide and phase sets (zeros exercise R3)
        foreach (divs[i]) begin
            foreach (sets[j]) begin
                configure(divs[i], sets[j][0], sets[j][1], sets[j][2], sets[j][3]);
                run_cmd(1, 1'b1, 1'b1, 0, 1'b0, "R2 R3 R7");
                run_cmd(0, 1'b0, 1'b1, 0, 1'b0, "R2 R3 R4");
                run_cmd(0, 1'b1, 1'b0, 0, 1'b0, "R2 R3 R6");
                run_cmd(0, 1'b1, 1'b1, 0, 1'b0, "R2 R3 R6");
                run_cmd(2, 1'b0, 1'b1, 0, 1'b0, "R2 R3 R7");
                run_cmd(3, 1'b0, 1'b1, 0, 1'b0, "R2 R3 R8");
            end
        end

        // realistic bus-speed settings
        configure(1, 5, 5, 5, 11);
        run_cmd(0, 1'b1, 1'b1, 0, 1'b0, "R2 fast-plus");
        configure(1, 15, 12, 12, 21);
        run_cmd(0, 1'b0, 1'b1, 0, 1'b0, "R2 fast");
        configure(10, 9, 6, 5, 4);
        run_cmd(0, 1'b1, 1'b1, 0, 1'b0, "R2 standard");

        // R10 clock stretching
        configure(1, 2, 2, 2, 2);
        run_cmd(0, 1'b1, 1'b1, 5, 1'b0, "R10 stretch bit");
        configure(2, 1, 3, 1, 1);
        run_cmd(1, 1'b1, 1'b1, 3, 1'b0, "R10 stretch start");

        // R11 timing fields changed while enabled are ignored
        configure(1, 2, 2, 2, 2);
        @(negedge clk);
        cfg_div = 8'd3; cfg_p0 = 8'd7; cfg_p3 = 8'd5;
        run_cmd(0, 1'b0, 1'b1, 0, 1'b0, "R11 fields frozen while enabled");
        configure(3, 7, 2, 2, 5);
        run_cmd(0, 1'b0, 1'b1, 0, 1'b0, "R11 fields loaded while disabled");

        // R13 command held during a cell
        configure(2, 1, 2, 1, 2);
        run_cmd(0, 1'b1, 1'b1, 0, 1'b1, "R13 command during cell");

        // R12 abort in mid-cell
        configure(2, 2, 2, 2, 2);
        @(negedge clk);
        cmd_kind = 2'd0; cmd_bit = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(scl_o === 1'b0 && sda_o === 1'b0, "R12 mid-cell levels before abort",
            int'({scl_o, sda_o}), 0);
        enable = 1'b0;
        @(negedge clk);
        #1;
        chk(scl_o === 1'b1 && sda_o === 1'b1 && done === 1'b0, "R12 released after abort",
            int'({scl_o, sda_o, done}), 6);
        chk(cmd_ready === 1'b0, "R12 not ready while disabled", int'(cmd_ready), 0);
        repeat (8) @(negedge clk);
        #1;
        chk(done === 1'b0 && scl_o === 1'b1, "R12 no late completion", int'({scl_o, done}), 2);
        enable = 1'b1;
        #1;
        chk(cmd_ready === 1'b1, "R12 idle after re-enable", int'(cmd_ready), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule